// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 64-bit Accumulator

This block holds a 64-bit accumulator made of an upper and a lower 32-bit half and updates it with products of two 32-bit operands. An operation is issued with a one-cycle `start_i` pulse, an operation code and two operands. The multiply-add, the multiply-subtract and the immediate multiply-add run on an iterative multiplier. That multiplier retires `STEP_W` bits of the second operand per cycle, so `busy_o` stays high for `DATA_W/STEP_W` cycles (4 by default). A `done_o` pulse marks the cycle in which the accumulator takes the new value.

Before it touches the accumulator, the product is cut down to its lower 32 bits and sign-extended to 64 bits. The 64-bit sum or difference wraps with no flag. The read-and-clear operation returns the lower half on `rdata_o`, signalled by a one-cycle `rd_valid_o`, and zeroes both halves in the same step.

A read-and-clear that arrives while a multiply is in flight is held back. It is served in the completion cycle, so it returns the lower half as that multiply leaves it. The full accumulator is visible on `acc_o` for the neighbouring datapath.

Top module: `mac_unit`

## Requirements
- R1: After reset, `acc_o` is zero, `busy_o`, `done_o` and `rd_valid_o` are low, and `rdata_o` is zero.
- R2: Operation code 4'h1 (multiply-add) adds the sign-extended lower 32 bits of `opa_i*opb_i` to the accumulator.
- R3: Operation code 4'h2 (multiply-subtract) subtracts the same sign-extended truncated product from the accumulator.
- R4: Operation code 4'h3 (immediate multiply-add) uses `opb_i[15:0]` sign-extended to 32 bits as the second factor, and `opb_i[31:16]` has no effect. It otherwise behaves as R2.
- R5: Operation code 4'h4 (read-and-clear), issued while idle, puts the lower half on `rdata_o` with `rd_valid_o` and `done_o` high one cycle later, and both halves read zero in that same cycle.
- R6: Accumulator arithmetic wraps modulo 2^64, carrying and borrowing across the two halves.
- R7: An accepted multiply operation keeps `busy_o` high for exactly `DATA_W/STEP_W` cycles. The accumulator changes on the last of them, and `done_o` pulses for one cycle as `busy_o` falls.
- R8: A multiply operation started while `busy_o` is high, and any other operation code (4'h0, 4'h5 to 4'hF), has no effect on any output.
- R9: A read-and-clear started while `busy_o` is high, including in the final busy cycle, returns the lower half after the pending multiply has been applied. Both halves are then zero, and `rd_valid_o` pulses with `done_o`. A second read-and-clear during the same busy period is absorbed into the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle operation request |
| op_i | input | 4 | Operation code (1 add, 2 subtract, 3 immediate add, 4 read-and-clear) |
| opa_i | input | 32 | First factor |
| opb_i | input | 32 | Second factor; bits 15:0 hold the immediate for code 3 |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | Operation completed this cycle |
| rd_valid_o | output | 1 | `rdata_o` carries a fresh read-and-clear result |
| rdata_o | output | 32 | Lower half captured by the last read-and-clear |
| acc_o | output | 64 | Current accumulator value |

## Verification
The assertions assume that `start_i` is a clean, fully defined level that is sampled only at clock edges, and that the operands are stable while it is high. They make no assumption about when requests arrive. A request during a busy period is legal, and the properties on accumulator stability and completion must hold under it. The stimulus drives every input on the falling edge and holds it for a whole cycle. It deliberately places requests inside busy periods, in the final busy cycle and back to back, so that the ignore and defer paths are covered without ever producing an undefined input.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [3:0] {
        MOP_MADD  = 4'h1,
        MOP_MSUB  = 4'h2,
        MOP_MADDI = 4'h3,
        MOP_RDCLR = 4'h4
    } mac_op_e;

    function automatic logic is_mul_op(input logic [3:0] op);
        return (op == MOP_MADD) || (op == MOP_MSUB) || (op == MOP_MADDI);
    endfunction

endpackage

// File: rtl/mac_mul_iter.sv
module mac_mul_iter #(
    parameter int DATA_W = 32,
    parameter int STEP_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              run_o,
    output logic              last_o,
    output logic [DATA_W-1:0] prod_o
);
    localparam int STEPS = DATA_W / STEP_W;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

    typedef struct packed {
        logic              run;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] p;
    } mul_st_t;

    mul_st_t                  st_q, st_d;
    logic [DATA_W+STEP_W-1:0] part;
    logic [DATA_W-1:0]        p_sum;

    // Only the lower DATA_W bits of the product are kept, so each step adds
    // a shifted partial product modulo 2^DATA_W.
    always_comb begin
        part  = {{STEP_W{1'b0}}, st_q.a} * {{DATA_W{1'b0}}, st_q.b[STEP_W-1:0]};
        p_sum = st_q.p + part[DATA_W-1:0];
        st_d  = st_q;
        if (load_i && !st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
            st_d.a   = a_i;
            st_d.b   = b_i;
            st_d.p   = '0;
        end else if (st_q.run) begin
            st_d.p   = p_sum;
            st_d.a   = st_q.a << STEP_W;
            st_d.b   = st_q.b >> STEP_W;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_CNT) begin
                st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.run;
    assign last_o = st_q.run && (st_q.cnt == LAST_CNT);
    assign prod_o = p_sum;

    a_r7_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.run |-> (st_q.cnt <= LAST_CNT));

    a_r7_last_stops_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> !run_o);

endmodule

// File: rtl/mac_acc_upd.sv
module mac_acc_upd #(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0]   prod_i,
    input  logic                sub_i,
    output logic [2*DATA_W-1:0] acc_o
);
    logic [2*DATA_W-1:0] ext;

    always_comb begin
        ext   = {{DATA_W{prod_i[DATA_W-1]}}, prod_i};
        acc_o = sub_i ? (acc_i - ext) : (acc_i + ext);
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int STEP_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [3:0]          op_i,
    input  logic [DATA_W-1:0]   opa_i,
    input  logic [DATA_W-1:0]   opb_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                rd_valid_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [2*DATA_W-1:0] acc_o
);
    import mac_pkg::*;

    localparam int ACC_W = 2 * DATA_W;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              rdv;
        logic              pend;
        logic              sub;
    } unit_st_t;

    unit_st_t          st_q, st_d;
    logic              mul_run, mul_last, mul_load, rc_req;
    logic [DATA_W-1:0] mul_prod, b_sel;
    logic [ACC_W-1:0]  acc_next;

    always_comb begin
        if (op_i == MOP_MADDI) begin
            b_sel = {{(DATA_W-IMM_W){opb_i[IMM_W-1]}}, opb_i[IMM_W-1:0]};
        end else begin
            b_sel = opb_i;
        end
    end

    assign rc_req   = start_i && (op_i == MOP_RDCLR);
    assign mul_load = start_i && !mul_run && is_mul_op(op_i);

    mac_mul_iter #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_mul (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (mul_load),
        .a_i    (opa_i),
        .b_i    (b_sel),
        .run_o  (mul_run),
        .last_o (mul_last),
        .prod_o (mul_prod)
    );

    mac_acc_upd #(.DATA_W(DATA_W)) u_upd (
        .acc_i  (st_q.acc),
        .prod_i (mul_prod),
        .sub_i  (st_q.sub),
        .acc_o  (acc_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.rdv  = 1'b0;
        if (mul_load) begin
            st_d.sub = (op_i == MOP_MSUB);
        end
        if (mul_last) begin
            st_d.done = 1'b1;
            if (st_q.pend || rc_req) begin
                st_d.rdata = acc_next[DATA_W-1:0];
                st_d.acc   = '0;
                st_d.rdv   = 1'b1;
                st_d.pend  = 1'b0;
            end else begin
                st_d.acc = acc_next;
            end
        end else if (mul_run) begin
            if (rc_req) begin
                st_d.pend = 1'b1;
            end
        end else if (rc_req) begin
            st_d.rdata = st_q.acc[DATA_W-1:0];
            st_d.acc   = '0;
            st_d.rdv   = 1'b1;
            st_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = mul_run;
    assign done_o     = st_q.done;
    assign rd_valid_o = st_q.rdv;
    assign rdata_o    = st_q.rdata;
    assign acc_o      = st_q.acc;

    a_r8_acc_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mul_run && !mul_last) |=> $stable(st_q.acc));

    a_r5_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> (acc_o == '0));

    a_r9_read_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> done_o);

    a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    a_r7_fall_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
    localparam int DW    = 32;
    localparam int SW    = 8;
    localparam int STEPS = DW / SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    op = 4'h0;
    logic [DW-1:0] opa = '0;
    logic [DW-1:0] opb = '0;
    logic          busy, done, rdv;
    logic [DW-1:0] rdata;
    logic [2*DW-1:0] acc;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    mac_unit #(.DATA_W(DW), .IMM_W(16), .STEP_W(SW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .opa_i(opa), .opb_i(opb), .busy_o(busy), .done_o(done),
        .rd_valid_o(rdv), .rdata_o(rdata), .acc_o(acc)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    logic [63:0] m_acc = '0;
    logic [31:0] m_prod = '0;
    logic [31:0] m_rdata = '0;
    logic        m_sub = 1'b0, m_pend = 1'b0, m_done = 1'b0, m_rdv = 1'b0;
    int          m_left = 0;

    always @(posedge clk) begin
        logic [31:0] bb;
        logic        rc;
        if (!rst_n) begin
            m_acc = '0; m_rdata = '0; m_pend = 0; m_done = 0; m_rdv = 0; m_left = 0;
        end else begin
            m_done = 0; m_rdv = 0;
            rc = start && (op == 4'h4);
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_sub) m_acc = m_acc - {{32{m_prod[31]}}, m_prod};
                    else       m_acc = m_acc + {{32{m_prod[31]}}, m_prod};
                    m_done = 1;
                    if (m_pend || rc) begin
                        m_rdata = m_acc[31:0]; m_acc = '0; m_rdv = 1; m_pend = 0;
                    end
                end else if (rc) begin
                    m_pend = 1;
                end
            end else if (start) begin
                if (op == 4'h1 || op == 4'h2 || op == 4'h3) begin
                    bb     = (op == 4'h3) ? {{16{opb[15]}}, opb[15:0]} : opb;
                    m_prod = opa * bb;
                    m_sub  = (op == 4'h2);
                    m_left = STEPS;
                end else if (op == 4'h4) begin
                    m_rdata = m_acc[31:0]; m_acc = '0; m_rdv = 1; m_done = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (busy !== (m_left > 0) || done !== m_done || rdv !== m_rdv ||
                rdata !== m_rdata || acc !== m_acc) begin
                n_fail++;
                $display("FAIL %s: busy=%0b done=%0b rdv=%0b rdata=%h acc=%h expected busy=%0b done=%0b rdv=%0b rdata=%h acc=%h",
                         cur_req, busy, done, rdv, rdata, acc,
                         (m_left > 0), m_done, m_rdv, m_rdata, m_acc);
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected completion earlier", cycles);
            finish_run();
        end
    end

    task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0; op = 4'h0; opa = '0; opb = '0;
    endtask

    task automatic settle();
        repeat (STEPS + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        repeat (2) @(negedge clk);
        issue(4'h4, 0, 0); settle();

        cur_req = "R2";
        issue(4'h1, 32'd3, 32'd5); settle();
        issue(4'h1, -32'sd7, 32'd9); settle();
        issue(4'h1, 32'h0001_0000, 32'h0001_0000); settle();   // truncates to 0
        issue(4'h1, 32'h0000_8000, 32'h0001_0000); settle();   // negative after truncation

        cur_req = "R3";
        issue(4'h2, 32'd100, 32'd4); settle();
        issue(4'h2, -32'sd3, -32'sd11); settle();

        cur_req = "R4";
        issue(4'h3, 32'd21, 32'h1234_FFFE); settle();
        issue(4'h3, 32'd5, 32'hABCD_0007); settle();

        cur_req = "R5";
        issue(4'h4, 0, 0); settle();
        issue(4'h4, 0, 0); settle();

        cur_req = "R6";
        issue(4'h2, 32'd1, 32'd1); settle();
        issue(4'h1, 32'd1, 32'd1); settle();
        issue(4'h1, 32'h7FFF_FFFF, 32'd1); settle();
        issue(4'h1, 32'h7FFF_FFFF, 32'd1); settle();
        issue(4'h1, 32'h7FFF_FFFF, 32'd1); settle();
        issue(4'h4, 0, 0); settle();

        cur_req = "R7";
        issue(4'h1, 32'd2, 32'd2);
        repeat (STEPS + 1) @(negedge clk);

        cur_req = "R8";
        @(negedge clk);
        start = 1; op = 4'h1; opa = 32'd10; opb = 32'd10;
        @(negedge clk);
        op = 4'h2; opa = 32'd77; opb = 32'd3;
        @(negedge clk);
        op = 4'h3;
        @(negedge clk);
        start = 0; op = 4'h0;
        settle();
        issue(4'h0, 32'd9, 32'd9); settle();
        issue(4'h7, 32'd9, 32'd9); settle();
        issue(4'hF, 32'd9, 32'd9); settle();

        cur_req = "R9";
        issue(4'h1, 32'd6, 32'd7);
        issue(4'h4, 0, 0); settle();
        issue(4'h1, 32'd6, 32'd7);
        issue(4'h4, 0, 0);
        issue(4'h4, 0, 0); settle();
        issue(4'h1, 32'd12, 32'd12);
        repeat (STEPS - 2) @(negedge clk);
        @(negedge clk);
        start = 1; op = 4'h4;                // lands in the last busy cycle
        @(negedge clk);
        start = 0; op = 4'h0;
        settle();

        cur_req = "R2";
        for (int i = 0; i < 300; i++) begin
            logic [3:0] o;
            o = 4'($urandom_range(0, 5));
            issue(o, $urandom, $urandom);
            repeat ($urandom_range(0, STEPS + 1)) @(negedge clk);
        end
        settle();
        finish_run();
    end

endmodule